// File: doc/BRIEF.md
# Draw Command Cycle Cost Accumulator

This block estimates how long a rendering engine will be busy with the drawing commands it is handed. Each command arrives in one cycle as a primitive kind (triangle, rectangle or line), a bounding width and height, and three modifier flags: textured, blended, and mask-checked. A global flag marks interlaced rendering. The block turns the command into an engine-tick cost, adds that cost to a pending-work counter, and removes two engine ticks from the counter on every system clock, because the engine runs at twice the system rate.

The pending count, an estimate of the remaining work in system clocks, and an idle flag go to the scheduler around the engine. The scheduler uses them to decide when results may be read back, or when the engine may be considered free. The block does not parse commands and does not draw pixels.

Top module: `drawcost_acc`

## Requirements
- R1: For a triangle (cmdKind 0), the per-row base is floor((width+2)/3). The cost is the per-row cost times the effective height.
- R2: For a rectangle (cmdKind 1), the per-row base is the full width. The cost is the per-row cost times the effective height.
- R3: For triangles and rectangles, cmdTextured adds the per-row base a second time to the per-row cost.
- R4: For triangles and rectangles, if cmdBlend or cmdMaskCheck is set, floor((base+1)/2) is added once to the per-row cost.
- R5: A line (cmdKind 2) costs max(width, effective height), and its textured, blend and mask flags have no effect.
- R6: With interlaceOn high, the effective height is max(floor(height/2), 1) for every kind. With interlaceOn low, it is the height itself.
- R7: Each clock, the pending count drops by 2 and never goes below 0.
- R8: A command accepted while the counter drains updates the counter in one step. The next value is max(pending-2, 0) plus the cost, visible on the cycle after cmdValid.
- R9: The pending count saturates at 2^ACC_W-1 and never wraps.
- R10: engineIdle is high exactly when the pending count is 0. Reset clears the count, so engineIdle is high after reset.
- R11: A command with cmdValid high and cmdKind 3 (reserved) adds nothing.
- R12: sysTicks is 0 when the pending count is 0. Otherwise it is max(floor(pending/2), 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdKind | input | 2 | 0 triangle, 1 rectangle, 2 line, 3 reserved |
| cmdWidth | input | WID_W | Bounding width in pixels |
| cmdHeight | input | HGT_W | Bounding height in pixels |
| cmdTextured | input | 1 | Command samples a texture |
| cmdBlend | input | 1 | Command is semi-transparent |
| cmdMaskCheck | input | 1 | Destination mask is tested before writing |
| interlaceOn | input | 1 | Interlaced rendering active |
| pendingTicks | output | ACC_W | Outstanding engine ticks |
| sysTicks | output | ACC_W-1 | Outstanding work in system clocks |
| engineIdle | output | 1 | No outstanding work |

## Verification
The drain and the addition of a new command's cost can occur in the same clock. The bench provokes this by issuing commands while the counter is nonzero, including back-to-back commands and a run of random commands with random gaps. A behavioural reference model applies "subtract two with a floor of zero, then add the cost, then clamp" once per clock. Its count, idle flag and system-tick estimate are compared with the outputs on every cycle, and the comparison stays active while the count sits at the odd value 1 and at the saturation ceiling.

// File: rtl/drawcost_pkg.sv
package drawcost_pkg;
  typedef enum logic [1:0] {
    KIND_TRI  = 2'd0,
    KIND_RECT = 2'd1,
    KIND_LINE = 2'd2,
    KIND_RSVD = 2'd3
  } prim_kind_e;

  typedef struct packed {
    logic addCost;
    logic drainTwo;
  } acc_strobe_t;
endpackage

// File: rtl/drawcost_calc.sv
module drawcost_calc
  import drawcost_pkg::*;
#(
  parameter int WID_W  = 10,
  parameter int HGT_W  = 9,
  parameter int COST_W = WID_W + 2 + HGT_W
) (
  input  prim_kind_e        kind,
  input  logic [WID_W-1:0]  wid,
  input  logic [HGT_W-1:0]  hgt,
  input  logic              textured,
  input  logic              blend,
  input  logic              maskCheck,
  input  logic              interlaceOn,
  output logic [COST_W-1:0] cost
);
  localparam int ROW_W = WID_W + 2;

  logic [HGT_W-1:0] hgtHalf, hgtEff;
  logic [WID_W:0]   avgSum, avgWid, base;
  logic [ROW_W-1:0] rowCost;
  logic [ROW_W-1:0] surcharge;
  logic [COST_W-1:0] areaCost, lineCost;

  always_comb begin
    // R6: interlaced rendering halves height, never below one row
    hgtHalf = hgt >> 1;
    if (interlaceOn) hgtEff = (hgtHalf == '0) ? HGT_W'(1) : hgtHalf;
    else             hgtEff = hgt;

    // R1: triangles use one third of the box width, rounded
    avgSum = {1'b0, wid} + (WID_W+1)'(2);
    avgWid = avgSum / (WID_W+1)'(3);
    // R2: rectangles use the full width
    base   = (kind == KIND_TRI) ? avgWid : {1'b0, wid};

    // R4: blend or mask test adds half a row, rounded up
    surcharge = (blend || maskCheck) ? ROW_W'((ROW_W'(base) + ROW_W'(1)) >> 1) : '0;
    // R3: texturing adds the base again
    rowCost   = ROW_W'(base) + (textured ? ROW_W'(base) : '0) + surcharge;

    areaCost = COST_W'(rowCost) * COST_W'(hgtEff);
    // R5: lines cost their longer side
    lineCost = (COST_W'(wid) > COST_W'(hgtEff)) ? COST_W'(wid) : COST_W'(hgtEff);

    unique case (kind)
      KIND_LINE: cost = lineCost;
      KIND_RSVD: cost = '0;
      default:   cost = areaCost;
    endcase
  end
endmodule

// File: rtl/drawcost_ctrl.sv
module drawcost_ctrl
  import drawcost_pkg::*;
(
  input  logic        cmdValid,
  input  prim_kind_e  kind,
  input  logic        accZero,
  output acc_strobe_t strobes
);
  always_comb begin
    // R11: the reserved kind never reaches the accumulator
    strobes.addCost  = cmdValid && (kind != KIND_RSVD);
    // R7: drain only while work remains
    strobes.drainTwo = !accZero;
  end
endmodule

// File: rtl/drawcost_dp.sv
module drawcost_dp
  import drawcost_pkg::*;
#(
  parameter int COST_W = 21,
  parameter int ACC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_strobe_t       strobes,
  input  logic [COST_W-1:0] cost,
  output logic [ACC_W-1:0]  pendingQ,
  output logic [ACC_W-2:0]  sysTicks,
  output logic              accZero
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic [ACC_W-1:0] TWO     = ACC_W'(2);

  logic [ACC_W-1:0] drained;
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] nextAcc;
  logic [ACC_W-2:0] halfAcc;

  always_comb begin
    // R7 / R8: drain applies to the old value, cost is added on top
    if (strobes.drainTwo) drained = (pendingQ >= TWO) ? pendingQ - TWO : '0;
    else                  drained = pendingQ;
    sum = {1'b0, drained} + (strobes.addCost ? (ACC_W+1)'(cost) : '0);
    // R9: clamp instead of wrapping
    nextAcc = sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pendingQ <= '0;
    else        pendingQ <= nextAcc;
  end

  always_comb begin
    accZero = (pendingQ == '0);
    halfAcc = pendingQ[ACC_W-1:1];
    // R12: engine-to-system conversion with a floor of one
    if (accZero)              sysTicks = '0;
    else if (halfAcc == '0)   sysTicks = (ACC_W-1)'(1);
    else                      sysTicks = halfAcc;
  end

  // R7
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strobes.addCost) && ($past(pendingQ) >= TWO) |-> pendingQ == $past(pendingQ) - TWO);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strobes.addCost) |->
      pendingQ >= (($past(pendingQ) > TWO) ? $past(pendingQ) - TWO : '0));

  // R12
  sys_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accZero |-> sysTicks != '0);
endmodule

// File: rtl/drawcost_acc.sv
module drawcost_acc
  import drawcost_pkg::*;
#(
  parameter int WID_W = 10,
  parameter int HGT_W = 9,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [1:0]       cmdKind,
  input  logic [WID_W-1:0] cmdWidth,
  input  logic [HGT_W-1:0] cmdHeight,
  input  logic             cmdTextured,
  input  logic             cmdBlend,
  input  logic             cmdMaskCheck,
  input  logic             interlaceOn,
  output logic [ACC_W-1:0] pendingTicks,
  output logic [ACC_W-2:0] sysTicks,
  output logic             engineIdle
);
  localparam int COST_W = WID_W + 2 + HGT_W;

  prim_kind_e        kind;
  acc_strobe_t       strobes;
  logic [COST_W-1:0] cost;
  logic              accZero;

  assign kind = prim_kind_e'(cmdKind);

  drawcost_calc #(.WID_W(WID_W), .HGT_W(HGT_W), .COST_W(COST_W)) calc_i (
    .kind(kind), .wid(cmdWidth), .hgt(cmdHeight), .textured(cmdTextured),
    .blend(cmdBlend), .maskCheck(cmdMaskCheck), .interlaceOn(interlaceOn), .cost(cost)
  );

  drawcost_ctrl ctrl_i (
    .cmdValid(cmdValid), .kind(kind), .accZero(accZero), .strobes(strobes)
  );

  drawcost_dp #(.COST_W(COST_W), .ACC_W(ACC_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .cost(cost),
    .pendingQ(pendingTicks), .sysTicks(sysTicks), .accZero(accZero)
  );

  assign engineIdle = accZero;

  // R11
  rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmdValid) && ($past(cmdKind) == 2'd3) && ($past(pendingTicks) == '0) |-> engineIdle);

  // R5
  line_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmdValid) && ($past(cmdKind) == 2'd2) && ($past(pendingTicks) == '0)
      |-> pendingTicks >= ACC_W'($past(cmdWidth)));

  // R10
  idle_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmdValid) && ($past(pendingTicks) == ACC_W'(2)) |-> engineIdle);
endmodule

// File: tb/drawcost_acc_tb_top.sv
`timescale 1ns/1ps
module drawcost_acc_tb_top;
  localparam int WID_W = 10;
  localparam int HGT_W = 9;
  localparam int ACC_W = 24;
  localparam longint SATV = (64'd1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdKind = '0;
  logic [WID_W-1:0] cmdWidth = '0;
  logic [HGT_W-1:0] cmdHeight = '0;
  logic cmdTextured = 1'b0, cmdBlend = 1'b0, cmdMaskCheck = 1'b0, interlaceOn = 1'b0;
  logic [ACC_W-1:0] pendingTicks;
  logic [ACC_W-2:0] sysTicks;
  logic engineIdle;

  int nCompared = 0;
  int nMismatched = 0;
  longint model = 0;

  always #4 clk = ~clk;

  drawcost_acc #(.WID_W(WID_W), .HGT_W(HGT_W), .ACC_W(ACC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdWidth(cmdWidth), .cmdHeight(cmdHeight), .cmdTextured(cmdTextured),
    .cmdBlend(cmdBlend), .cmdMaskCheck(cmdMaskCheck), .interlaceOn(interlaceOn),
    .pendingTicks(pendingTicks), .sysTicks(sysTicks), .engineIdle(engineIdle)
  );

  function automatic longint refCost(int k, int w, int h, bit t, bit b, bit m, bit il);
    longint he, base, row;
    he = il ? ((h / 2 < 1) ? 1 : h / 2) : h;
    if (k == 3) return 0;
    if (k == 2) return (w > he) ? w : he;
    base = (k == 0) ? (w + 2) / 3 : w;
    row = base;
    if (t) row += base;
    if (b || m) row += (base + 1) / 2;
    return row * he;
  endfunction

  task automatic checkVal(string tag, string what, longint act, longint exp);
    nCompared++;
    if (act != exp) begin
      nMismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    longint expSys;
    expSys = (model == 0) ? 0 : ((model / 2 < 1) ? 1 : model / 2);
    checkVal(tag, "pendingTicks", longint'(pendingTicks), model);
    checkVal("R10", "engineIdle", longint'(engineIdle), (model == 0) ? 1 : 0);
    checkVal("R12", "sysTicks", longint'(sysTicks), expSys);
  endtask

  task automatic step(string tag, bit v, int k, int w, int h, bit t, bit b, bit m, bit il);
    longint nxt;
    cmdValid = v; cmdKind = 2'(k); cmdWidth = WID_W'(w); cmdHeight = HGT_W'(h);
    cmdTextured = t; cmdBlend = b; cmdMaskCheck = m; interlaceOn = il;
    @(posedge clk);
    nxt = (model >= 2) ? model - 2 : 0;
    if (v) nxt += refCost(k, w, h, t, b, m, il);
    model = (nxt > SATV) ? SATV : nxt;
    @(negedge clk);
    cmdValid = 1'b0;
    compareAll(tag);
  endtask

  task automatic idleStep(string tag);
    step(tag, 1'b0, 0, 0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drainAll(string tag);
    for (int i = 0; i < 20000 && model != 0; i++) idleStep(tag);
    idleStep(tag);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model = 0;
    compareAll("R10");
  endtask

  initial begin
    #(8ns * 200000);
    nMismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 plain triangle: (10+2)/3=4 per row, 4 rows -> 16
    step("R1", 1, 0, 10, 4, 0, 0, 0, 0);
    drainAll("R7");
    step("R1", 1, 0, 1, 7, 0, 0, 0, 0);
    drainAll("R7");
    // R3 / R4 on triangles
    step("R3", 1, 0, 20, 3, 1, 0, 0, 0);
    drainAll("R7");
    step("R4", 1, 0, 20, 3, 0, 1, 0, 0);
    drainAll("R7");
    step("R4", 1, 0, 21, 5, 1, 0, 1, 0);
    drainAll("R7");
    // R2 rectangles
    step("R2", 1, 1, 13, 6, 0, 0, 0, 0);
    drainAll("R7");
    step("R3", 1, 1, 13, 6, 1, 0, 1, 0);
    drainAll("R7");
    step("R4", 1, 1, 7, 2, 0, 1, 1, 0);
    drainAll("R7");
    // R5 lines ignore modifier flags
    step("R5", 1, 2, 5, 20, 1, 1, 1, 0);
    drainAll("R7");
    step("R5", 1, 2, 30, 4, 1, 0, 1, 0);
    drainAll("R7");
    // R6 interlace
    step("R6", 1, 1, 9, 1, 0, 0, 0, 1);
    drainAll("R7");
    step("R6", 1, 2, 3, 20, 0, 0, 0, 1);
    drainAll("R7");
    step("R6", 1, 0, 30, 0, 0, 0, 0, 1);
    drainAll("R7");
    step("R6", 1, 1, 30, 0, 0, 0, 0, 0);
    idleStep("R6");
    step("R6", 1, 0, 40, 9, 1, 1, 0, 1);
    drainAll("R7");
    // R11 reserved kind adds nothing
    step("R11", 1, 3, 500, 200, 1, 1, 1, 0);
    idleStep("R11");
    // R12 odd remainder: 3 -> 1 -> 0
    step("R12", 1, 1, 3, 1, 0, 0, 0, 0);
    idleStep("R12");
    idleStep("R12");
    // R8 back-to-back commands while draining
    step("R8", 1, 1, 10, 10, 0, 0, 0, 0);
    step("R8", 1, 0, 8, 2, 1, 0, 0, 0);
    idleStep("R8");
    step("R8", 1, 2, 9, 1, 0, 0, 0, 0);
    step("R8", 1, 1, 1, 1, 0, 0, 0, 0);
    drainAll("R7");
    // R8 random mix with gaps
    for (int i = 0; i < 400; i++) begin
      step("R8", ($urandom % 4) == 0, int'($urandom % 4), int'($urandom % 32),
           int'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    doReset();
    // R9 saturation with the largest commands
    for (int i = 0; i < 16; i++) step("R9", 1, 1, 1023, 511, 1, 1, 0, 0);
    step("R9", 1, 0, 1023, 511, 1, 1, 1, 0);
    idleStep("R9");
    idleStep("R9");
    doReset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end
endmodule